// File: doc/BRIEF.md
# Inductive Crosstalk Transition Checker

This block judges one bus transition for a pin segment that has a supply pin at each end and signal pins between them. It takes the previous and next values of the segment's own signal pins and the edge activity of the segments on either side. It then checks the transition against three families of inductive-noise limits. The first limit covers current through the supply pins. The second covers coupled glitches on signal pins that hold still. The third covers coupling that works against a signal pin that is switching.

Each pin gets a three-valued direction: rising, falling or static. For every signal pin the block forms a signed sum over its neighbours on both sides, up to a reach of three. Each neighbour's direction is scaled by an integer weight that depends on its distance. Neighbours past the edge of the segment come from the adjacent segments. The block compares each sum with integer thresholds. It also counts rising and falling pins to check supply bounce. The result is registered and is valid one cycle after a strobed input. An encoder can use it to decide whether a transition is legal or must be split with intermediate states.

Top module: `xtalk_rule_checker`

## Requirements
- R1: Own pin direction is derived per bit: 0→1 is rising (+1), 1→0 is falling (−1), and an unchanged bit is static (0). A neighbour-segment pin with only its rise bit set is +1, with only its fall bit set is −1, and with neither bit or both bits set is 0.
- R2: The coupling sum of a signal pin is the sum over q = 1..REACH of K_q × (direction of the pin q places lower + direction of the pin q places higher). Pin positions run 0..SEG_PINS−1, and signal bit s sits at position s+1. Positions below 0 map into the lower segment at position + SEG_PINS, and positions above SEG_PINS−1 map into the upper segment at position − SEG_PINS. Supply positions always count as 0.
- R3: A static signal pin violates when its sum is not strictly between −GLITCH_LIM and +GLITCH_LIM.
- R4: A rising signal pin violates when its sum is not strictly greater than RISE_MIN.
- R5: A falling signal pin violates when its sum is not strictly less than FALL_MAX.
- R6: The supply pin at position 0 violates when SUPPLY_STEP × (number of rising own pins) is not less than 2 × BOUNCE_LIM. This is the halved per-pin step compared against the limit.
- R7: The supply pin at position SEG_PINS−1 violates when SUPPLY_STEP × (number of falling own pins) is not less than 2 × BOUNCE_LIM.
- R8: The layout of `viol` (3·SEG_PINS−4 bits) is as follows. Bit 0 is the R6 rule. For signal bit s, bit 3s+1 is its static rule, bit 3s+2 its rising rule and bit 3s+3 its falling rule. The top bit is the R7 rule. At most one of the three bits of a pin is set.
- R9: The result appears on `viol`/`pass` with `out_valid` high in the cycle after `in_valid` is high. When `in_valid` is low, `out_valid` is low and `viol`/`pass` hold their values.
- R10: `pass` is high exactly when no bit of the registered `viol` is set.
- R11: After reset, `out_valid` is 0, `viol` is all zero and `pass` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Strobe: evaluate the present inputs |
| prev_sig | input | SEG_PINS-2 | Previous values of own signal pins |
| next_sig | input | SEG_PINS-2 | Next values of own signal pins |
| lo_rise | input | SEG_PINS-2 | Rising flags of the lower segment's signal pins |
| lo_fall | input | SEG_PINS-2 | Falling flags of the lower segment's signal pins |
| hi_rise | input | SEG_PINS-2 | Rising flags of the upper segment's signal pins |
| hi_fall | input | SEG_PINS-2 | Falling flags of the upper segment's signal pins |
| out_valid | output | 1 | Result valid pulse |
| pass | output | 1 | No rule violated |
| viol | output | 3*SEG_PINS-4 | Per-rule violation flags |

## Verification
The hardest situation to reach from the ports is coupling across a segment boundary. The supply pins shield the edge signals, so a pin in a neighbouring segment reaches an own victim only at the full reach of three, and only with the smallest weight. The bench sets a single edge of the upper segment against a rising edge pin so that this one weight decides the result. It repeats the same case with both flags set, and sweeps every own transition against several neighbour patterns. The expected values come from a flat model that places three segments side by side.

// File: rtl/xtalk_rule_checker.sv
module xtalk_rule_checker #(
  parameter int SEG_PINS    = 5,
  parameter int REACH       = 3,
  parameter int K1          = 4,
  parameter int K2          = 2,
  parameter int K3          = 1,
  parameter int GLITCH_LIM  = 4,
  parameter int RISE_MIN    = -1,
  parameter int FALL_MAX    = 1,
  parameter int SUPPLY_STEP = 2,
  parameter int BOUNCE_LIM  = 3,
  localparam int SIG        = SEG_PINS - 2,
  localparam int VW         = 3 * SEG_PINS - 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [SIG-1:0] prev_sig,
  input  logic [SIG-1:0] next_sig,
  input  logic [SIG-1:0] lo_rise,
  input  logic [SIG-1:0] lo_fall,
  input  logic [SIG-1:0] hi_rise,
  input  logic [SIG-1:0] hi_fall,
  output logic           out_valid,
  output logic           pass,
  output logic [VW-1:0]  viol
);

  localparam int PAD  = 3;
  localparam int RCH  = (REACH > PAD) ? PAD : ((REACH < 1) ? 1 : REACH);
  localparam int EXT  = SEG_PINS + 2 * PAD;

  function automatic int dir3(input logic r, input logic f);
    return (r && !f) ? 1 : ((f && !r) ? -1 : 0);
  endfunction

  function automatic int wgt(input int q);
    return (q == 1) ? K1 : ((q == 2) ? K2 : K3);
  endfunction

  logic [SIG-1:0] own_rise, own_fall;
  int             ext  [EXT];
  int             wsum [SIG];
  int             n_rise, n_fall;
  logic [VW-1:0]  viol_d;

  assign own_rise = next_sig & ~prev_sig;
  assign own_fall = prev_sig & ~next_sig;
  assign n_rise   = $countones(own_rise);
  assign n_fall   = $countones(own_fall);

  always_comb begin
    for (int e = 0; e < EXT; e++) ext[e] = 0;
    for (int k = 1; k <= SIG; k++) begin
      if (PAD + k - SEG_PINS >= 0)
        ext[PAD + k - SEG_PINS] = dir3(lo_rise[k-1], lo_fall[k-1]);
      ext[PAD + k] = dir3(own_rise[k-1], own_fall[k-1]);
      if (PAD + SEG_PINS + k < EXT)
        ext[PAD + SEG_PINS + k] = dir3(hi_rise[k-1], hi_fall[k-1]);
    end
  end

  always_comb begin
    for (int s = 0; s < SIG; s++) begin
      wsum[s] = 0;
      for (int q = 1; q <= RCH; q++)
        wsum[s] = wsum[s] + wgt(q) * (ext[PAD + s + 1 - q] + ext[PAD + s + 1 + q]);
    end
  end

  assign viol_d[0]    = !(SUPPLY_STEP * n_rise < 2 * BOUNCE_LIM);
  assign viol_d[VW-1] = !(SUPPLY_STEP * n_fall < 2 * BOUNCE_LIM);

  for (genvar s = 0; s < SIG; s++) begin : g_pin
    assign viol_d[3*s+1] = !own_rise[s] && !own_fall[s] &&
                           !(wsum[s] > -GLITCH_LIM && wsum[s] < GLITCH_LIM);
    assign viol_d[3*s+2] = own_rise[s] && !(wsum[s] > RISE_MIN);
    assign viol_d[3*s+3] = own_fall[s] && !(wsum[s] < FALL_MAX);

    AST_ONE_CASE_PER_PIN: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(viol[3*s+3 -: 3])); // R8
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      viol      <= '0;
      pass      <= 1'b1;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        viol <= viol_d;
        pass <= ~|viol_d;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R9
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R9
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(viol) && $stable(pass)); // R9
  AST_PASS_NOR: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (pass == (viol == '0))); // R10
  AST_VDD_BOUNCE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (SUPPLY_STEP * $countones(next_sig & ~prev_sig) >= 2 * BOUNCE_LIM)
    |=> viol[0]); // R6
  AST_VSS_BOUNCE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (SUPPLY_STEP * $countones(prev_sig & ~next_sig) >= 2 * BOUNCE_LIM)
    |=> viol[VW-1]); // R7

  if (GLITCH_LIM > 0 && BOUNCE_LIM > 0) begin : g_quiet
    AST_QUIET_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && (prev_sig == next_sig) && ((lo_rise ^ lo_fall) == '0) &&
      ((hi_rise ^ hi_fall) == '0) |=> (viol == '0)); // R3
  end

endmodule

// File: tb/xtalk_rule_checker_bench.sv
module xtalk_rule_checker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 5;
  localparam int S = N - 2;
  localparam int W = 3 * N - 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [S-1:0] prev_sig = '0, next_sig = '0;
  logic [S-1:0] lo_rise = '0, lo_fall = '0, hi_rise = '0, hi_fall = '0;
  logic out_valid, pass;
  logic [W-1:0] viol;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xtalk_rule_checker u_xtalk_rule_checker (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .prev_sig(prev_sig), .next_sig(next_sig),
    .lo_rise(lo_rise), .lo_fall(lo_fall), .hi_rise(hi_rise), .hi_fall(hi_fall),
    .out_valid(out_valid), .pass(pass), .viol(viol));

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int d3(input logic r, input logic f);
    return (r && !f) ? 1 : ((f && !r) ? -1 : 0);
  endfunction

  // flat model: three segments side by side, own segment at positions N..2N-1
  function automatic logic [W-1:0] model(input logic [S-1:0] p, input logic [S-1:0] n,
      input logic [S-1:0] lr, input logic [S-1:0] lf,
      input logic [S-1:0] hr, input logic [S-1:0] hf);
    int g [3*N];
    int k [4];
    logic [W-1:0] v;
    int nr, nf, sum, t;
    k[0] = 0; k[1] = 4; k[2] = 2; k[3] = 1;
    for (int i = 0; i < 3*N; i++) g[i] = 0;
    nr = 0; nf = 0;
    for (int s = 0; s < S; s++) begin
      g[s+1]       = d3(lr[s], lf[s]);
      g[N+s+1]     = d3(!p[s] && n[s], p[s] && !n[s]);
      g[2*N+s+1]   = d3(hr[s], hf[s]);
      if (!p[s] && n[s]) nr++;
      if (p[s] && !n[s]) nf++;
    end
    v = '0;
    v[0]   = !(2 * nr < 6);
    v[W-1] = !(2 * nf < 6);
    for (int s = 0; s < S; s++) begin
      sum = 0;
      for (int q = 1; q <= 3; q++) sum += k[q] * (g[N+s+1-q] + g[N+s+1+q]);
      t = g[N+s+1];
      if (t == 0)  v[3*s+1] = !(sum > -4 && sum < 4);
      if (t == 1)  v[3*s+2] = !(sum > -1);
      if (t == -1) v[3*s+3] = !(sum < 1);
    end
    return v;
  endfunction

  task automatic apply(input logic [S-1:0] p, input logic [S-1:0] n,
      input logic [S-1:0] lr, input logic [S-1:0] lf,
      input logic [S-1:0] hr, input logic [S-1:0] hf);
    @(negedge clk);
    prev_sig = p; next_sig = n; lo_rise = lr; lo_fall = lf; hi_rise = hr; hi_fall = hf;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R11 out_valid", W'(out_valid), W'(0));
    chk("R11 viol", viol, '0);
    chk("R11 pass", W'(pass), W'(1));
  endtask

  task automatic t_hand;
    apply(3'b000, 3'b111, '0, '0, '0, '0);
    chk("R6 all rising", viol, 11'h001);
    chk("R9 out_valid", W'(out_valid), W'(1));
    chk("R10 pass low", W'(pass), W'(0));
    apply(3'b111, 3'b000, '0, '0, '0, '0);
    chk("R7 all falling", viol, 11'h400);
    apply(3'b000, 3'b010, '0, '0, '0, '0);
    chk("R3 glitch on static neighbours", viol, 11'h082);
    apply(3'b001, 3'b010, '0, '0, '0, '0);
    chk("R4 R5 opposing edges", viol, 11'h028);
    apply(3'b101, 3'b101, '0, '0, '0, '0);
    chk("R8 quiet segment", viol, '0);
    chk("R10 pass high", W'(pass), W'(1));
  endtask

  task automatic t_hold;
    @(negedge clk);
    prev_sig = 3'b000; next_sig = 3'b111;
    @(negedge clk);
    chk("R9 idle out_valid", W'(out_valid), W'(0));
    chk("R9 held viol", viol, '0);
    chk("R9 held pass", W'(pass), W'(1));
  endtask

  task automatic t_wrap;
    apply(3'b000, 3'b100, '0, '0, '0, 3'b001);
    chk("R2 upper segment coupling", viol, 11'h110);
    apply(3'b000, 3'b100, '0, '0, 3'b001, 3'b001);
    chk("R1 both flags static", viol, 11'h010);
    apply(3'b000, 3'b001, 3'b100, '0, '0, '0);
    chk("R2 lower segment aiding", viol, model(3'b000, 3'b001, 3'b100, '0, '0, '0));
  endtask

  task automatic t_sweep;
    logic [S-1:0] pats [4][4];
    pats[0] = '{3'b000, 3'b000, 3'b000, 3'b000};
    pats[1] = '{3'b100, 3'b000, 3'b000, 3'b001};
    pats[2] = '{3'b000, 3'b110, 3'b011, 3'b000};
    pats[3] = '{3'b101, 3'b010, 3'b110, 3'b001};
    for (int pt = 0; pt < 4; pt++)
      for (int a = 0; a < 8; a++)
        for (int b = 0; b < 8; b++) begin
          apply(S'(a), S'(b), pats[pt][0], pats[pt][1], pats[pt][2], pats[pt][3]);
          chk("R1 R3 R4 R5 R6 R7 sweep", viol,
              model(S'(a), S'(b), pats[pt][0], pats[pt][1], pats[pt][2], pats[pt][3]));
          chk("R10 sweep pass", W'(pass),
              W'(model(S'(a), S'(b), pats[pt][0], pats[pt][1], pats[pt][2], pats[pt][3]) == '0));
        end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_hand();
    t_hold();
    t_wrap();
    t_sweep();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule